// File: doc/BRIEF.md
# Ring-Rotating Stationary-Weight MAC Array

This block computes a 1x1 convolution, which is a signed matrix-vector product `out[oc] = sum over ic of w[oc][ic] * a[ic]`. The work is spread over a closed ring of `N` processing elements. Element `i` owns output channels `i*OUT_CH/N` and up. It keeps the weight rows for those channels, across every input channel, fixed for the whole run. At the start it holds one slice of `IN_CH/N` input activations. A single shared controller steps all elements through `N` phases. In each phase every element runs one multiply-accumulate per cycle, pairing the activation slice it currently holds with the matching weight columns. After that, every element hands its slice, together with a group tag, to the next element in the ring in one cycle.

Partial sums never leave an element. At the end each element holds finished 32-bit outputs for its own output channels, so the result sits in the same distributed layout as the input. Software writes weights and activations through a load port while the array is idle. It pulses `start`, waits for the one-cycle `done` pulse, and then reads any output channel combinationally through the read port. Each activation slice carries its group tag as it moves. Because of this, a later load or a restart without reload still lands on the correct data even though the slices have rotated.

Top module: `ring_mac_array`

## Requirements
- R1: After reset, `busy` and `done` are low and every output channel reads 0 on `rdData`.
- R2: After `done`, `rdData` for output channel `oc` equals the sum over all input channels `ic` of `w[oc][ic]*a[ic]`. Weights and activations are signed 8-bit two's complement, and the sum is a 32-bit two's complement value.
- R3: Call the clock edge that samples an accepted `start` edge 1. `done` is high for exactly one cycle, and that cycle follows edge `IN_CH*OUT_CH/N + N`.
- R4: `busy` goes high at the edge that accepts `start`. It stays high through the `done` cycle and is low in the cycle after it.
- R5: A `start` pulse while `busy` is high has no effect. The `done` timing and the results of the run in progress are unchanged.
- R6: A weight write (`ldWe`) or activation write (`ldAe`) while `busy` is high is dropped. Later results are computed as if it never happened.
- R7: A new `start` clears all accumulators. A restart with no reload gives the same results as the previous run.
- R8: When idle, `ldWe` writes `ldData` to weight (`ldRow` = output channel, `ldCol` = input channel), and `ldAe` writes `ldData` to activation `ldCol`. Such writes take effect on the next run even after a previous run has rotated the activation slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset |
| ldWe | input | 1 | Write `ldData` into weight (`ldRow`, `ldCol`) |
| ldAe | input | 1 | Write `ldData` into activation `ldCol` |
| ldRow | input | clog2(OUT_CH) | Output-channel index for weight writes |
| ldCol | input | clog2(IN_CH) | Input-channel index for weight and activation writes |
| ldData | input | 8 | Signed load value |
| start | input | 1 | Begin a computation (accepted only while idle) |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdRow | input | clog2(OUT_CH) | Output channel to read |
| rdData | output | 32 | Accumulated result of output channel `rdRow` |

## Verification
Suppose an element pairs an activation slice with the wrong weight columns, or a slice or tag goes astray in the ring. Only that element's output channels go wrong, and this shows up on `rdData` right after `done`. The bench uses random data, so such an error almost never cancels out. A phase or step counter that is off by one moves `done` away from its exact cycle, and a cycle-exact latency check catches this on the first run. Stale tags after rotation stay invisible until the next idle-time load or restart. For that reason the bench reloads single values and restarts without reloading, and compares the results each time.

// File: rtl/ring_mac_pkg.sv
`timescale 1ns/1ps
package ring_mac_pkg;
  // Common index width carried in the control strobes (covers all supported sizes)
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             loadOk;   // idle: load port writes are allowed
    logic             clearAcc; // zero every accumulator
    logic             macEn;    // perform one MAC in every element
    logic             shiftEn;  // rotate activation slices one hop
    logic [IDX_W-1:0] rowSel;   // local output row of this MAC
    logic [IDX_W-1:0] colSel;   // slot within the held activation slice
  } ringCtrl_t;
endpackage

// File: rtl/ring_mac_pe.sv
`timescale 1ns/1ps
module ring_mac_pe
  import ring_mac_pkg::*;
#(
  parameter int N      = 4,
  parameter int IN_CH  = 8,
  parameter int OUT_CH = 8,
  parameter int PE_ID  = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  ringCtrl_t           ctrl,
  input  logic                wEn,
  input  logic [IDX_W-1:0]    wRow,
  input  logic [IDX_W-1:0]    wCol,
  input  logic                aEn,
  input  logic [IDX_W-1:0]    aGroup,
  input  logic [IDX_W-1:0]    aSlot,
  input  logic signed [7:0]   ldData,
  input  logic signed [7:0]   actIn [IN_CH/N],
  input  logic [IDX_W-1:0]    tagIn,
  output logic signed [7:0]   actOut [IN_CH/N],
  output logic [IDX_W-1:0]    tagOut,
  output logic signed [31:0]  accOut [OUT_CH/N]
);
  localparam int ICG    = IN_CH / N;
  localparam int OCG    = OUT_CH / N;
  localparam int ROW_W  = (OCG > 1) ? $clog2(OCG) : 1;
  localparam int SLOT_W = (ICG > 1) ? $clog2(ICG) : 1;
  localparam int COL_W  = (IN_CH > 1) ? $clog2(IN_CH) : 1;

  logic signed [7:0]  wMem [OCG][IN_CH];
  logic signed [7:0]  actReg [ICG];
  logic [IDX_W-1:0]   tagReg;
  logic signed [31:0] accReg [OCG];

  logic [ROW_W-1:0]   macRow;
  logic [SLOT_W-1:0]  macSlot;
  logic [COL_W-1:0]   macCol;
  logic signed [15:0] product;
  logic [ROW_W-1:0]   ldRowI;
  logic [COL_W-1:0]   ldColI;
  logic [SLOT_W-1:0]  ldSlotI;

  always_comb begin
    macRow  = ctrl.rowSel[ROW_W-1:0];
    macSlot = ctrl.colSel[SLOT_W-1:0];
    // weight column = first input channel of the held group + slot
    macCol  = COL_W'(int'(tagReg) * ICG + int'(macSlot));
    product = actReg[macSlot] * wMem[macRow][macCol];
    ldRowI  = wRow[ROW_W-1:0];
    ldColI  = wCol[COL_W-1:0];
    ldSlotI = aSlot[SLOT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < OCG; r++) begin
        for (int c = 0; c < IN_CH; c++) wMem[r][c] <= '0;
        accReg[r] <= '0;
      end
      for (int s = 0; s < ICG; s++) actReg[s] <= '0;
      tagReg <= IDX_W'(PE_ID);
    end else begin
      if (wEn) wMem[ldRowI][ldColI] <= ldData;

      if (ctrl.shiftEn) begin
        for (int s = 0; s < ICG; s++) actReg[s] <= actIn[s];
        tagReg <= tagIn;
      end else if (aEn && (aGroup == tagReg)) begin
        actReg[ldSlotI] <= ldData;
      end

      if (ctrl.clearAcc) begin
        for (int r = 0; r < OCG; r++) accReg[r] <= '0;
      end else if (ctrl.macEn) begin
        accReg[macRow] <= accReg[macRow] + 32'(product);
      end
    end
  end

  always_comb begin
    for (int s = 0; s < ICG; s++) actOut[s] = actReg[s];
    for (int r = 0; r < OCG; r++) accOut[r] = accReg[r];
    tagOut = tagReg;
  end
endmodule

// File: rtl/ring_mac_datapath.sv
`timescale 1ns/1ps
module ring_mac_datapath
  import ring_mac_pkg::*;
#(
  parameter int N      = 4,
  parameter int IN_CH  = 8,
  parameter int OUT_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringCtrl_t         ctrl,
  input  logic              ldWe,
  input  logic              ldAe,
  input  logic [IDX_W-1:0]  ldRow,
  input  logic [IDX_W-1:0]  ldCol,
  input  logic [7:0]        ldData,
  input  logic [IDX_W-1:0]  rdRow,
  output logic [31:0]       rdData
);
  localparam int ICG   = IN_CH / N;
  localparam int OCG   = OUT_CH / N;
  localparam int PE_W  = (N > 1) ? $clog2(N) : 1;
  localparam int ROW_W = (OCG > 1) ? $clog2(OCG) : 1;

  logic signed [7:0]  actBus [N][ICG];
  logic [IDX_W-1:0]   tagBus [N];
  logic signed [31:0] accBus [N][OCG];

  logic [IDX_W-1:0] wPeSel, wRowLoc, aGroup, aSlot, rdPeSel, rdLoc;
  logic [PE_W-1:0]  rdPeI;
  logic [ROW_W-1:0] rdLocI;

  always_comb begin
    wPeSel  = IDX_W'(int'(ldRow) / OCG);
    wRowLoc = IDX_W'(int'(ldRow) % OCG);
    aGroup  = IDX_W'(int'(ldCol) / ICG);
    aSlot   = IDX_W'(int'(ldCol) % ICG);
    rdPeSel = IDX_W'(int'(rdRow) / OCG);
    rdLoc   = IDX_W'(int'(rdRow) % OCG);
    rdPeI   = rdPeSel[PE_W-1:0];
    rdLocI  = rdLoc[ROW_W-1:0];
  end

  for (genvar i = 0; i < N; i++) begin : g_pe
    localparam int UPSTREAM = (i + N - 1) % N;
    logic peWEn;
    assign peWEn = ctrl.loadOk & ldWe & (wPeSel == IDX_W'(i));

    ring_mac_pe #(
      .N(N), .IN_CH(IN_CH), .OUT_CH(OUT_CH), .PE_ID(i)
    ) u_pe (
      .clk    (clk),
      .rstN   (rstN),
      .ctrl   (ctrl),
      .wEn    (peWEn),
      .wRow   (wRowLoc),
      .wCol   (ldCol),
      .aEn    (ctrl.loadOk & ldAe),
      .aGroup (aGroup),
      .aSlot  (aSlot),
      .ldData (ldData),
      .actIn  (actBus[UPSTREAM]),
      .tagIn  (tagBus[UPSTREAM]),
      .actOut (actBus[i]),
      .tagOut (tagBus[i]),
      .accOut (accBus[i])
    );
  end

  assign rdData = accBus[rdPeI][rdLocI];
endmodule

// File: rtl/ring_mac_ctrl.sv
`timescale 1ns/1ps
module ring_mac_ctrl
  import ring_mac_pkg::*;
#(
  parameter int N      = 4,
  parameter int IN_CH  = 8,
  parameter int OUT_CH = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output ringCtrl_t ctrl,
  output logic      busy,
  output logic      done
);
  localparam int ICG  = IN_CH / N;
  localparam int OCG  = OUT_CH / N;
  localparam int PH_W = 3;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_SHIFT, S_FIN} state_t;

  state_t           state;
  logic [IDX_W-1:0] rowCnt, colCnt;
  logic [PH_W-1:0]  phase;
  logic             lastCol, lastRow, lastPhase;

  assign lastCol   = (colCnt == IDX_W'(ICG - 1));
  assign lastRow   = (rowCnt == IDX_W'(OCG - 1));
  assign lastPhase = (phase == PH_W'(N - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      rowCnt <= '0;
      colCnt <= '0;
      phase  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state  <= S_RUN;
          rowCnt <= '0;
          colCnt <= '0;
          phase  <= '0;
        end
        S_RUN: begin
          if (lastCol) begin
            colCnt <= '0;
            if (lastRow) begin
              rowCnt <= '0;
              state  <= lastPhase ? S_FIN : S_SHIFT;
            end else begin
              rowCnt <= rowCnt + 1'b1;
            end
          end else begin
            colCnt <= colCnt + 1'b1;
          end
        end
        S_SHIFT: begin
          phase <= phase + 1'b1;
          state <= S_RUN;
        end
        S_FIN: begin
          phase <= '0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl          = '0;
    ctrl.loadOk   = (state == S_IDLE);
    ctrl.clearAcc = (state == S_IDLE) && start;
    ctrl.macEn    = (state == S_RUN);
    ctrl.shiftEn  = (state == S_SHIFT);
    ctrl.rowSel   = rowCnt;
    ctrl.colSel   = colCnt;
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);
endmodule

// File: rtl/ring_mac_array.sv
`timescale 1ns/1ps
module ring_mac_array
  import ring_mac_pkg::*;
#(
  parameter  int N      = 4,
  parameter  int IN_CH  = 8,
  parameter  int OUT_CH = 8,
  localparam int IC_W   = (IN_CH > 1) ? $clog2(IN_CH) : 1,
  localparam int OC_W   = (OUT_CH > 1) ? $clog2(OUT_CH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ldWe,
  input  logic            ldAe,
  input  logic [OC_W-1:0] ldRow,
  input  logic [IC_W-1:0] ldCol,
  input  logic [7:0]      ldData,
  input  logic            start,
  output logic            busy,
  output logic            done,
  input  logic [OC_W-1:0] rdRow,
  output logic [31:0]     rdData
);
  ringCtrl_t ctrl;

  ring_mac_ctrl #(.N(N), .IN_CH(IN_CH), .OUT_CH(OUT_CH)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  ring_mac_datapath #(.N(N), .IN_CH(IN_CH), .OUT_CH(OUT_CH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .ldWe   (ldWe),
    .ldAe   (ldAe),
    .ldRow  (IDX_W'(ldRow)),
    .ldCol  (IDX_W'(ldCol)),
    .ldData (ldData),
    .rdRow  (IDX_W'(rdRow)),
    .rdData (rdData)
  );
endmodule

// File: rtl/ring_mac_array_chk.sv
`timescale 1ns/1ps
module ring_mac_array_chk #(
  parameter int N      = 4,
  parameter int IN_CH  = 8,
  parameter int OUT_CH = 8
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done
);
  localparam int LAT = (IN_CH * OUT_CH) / N + N - 1;

  int busyCyc;
  always_ff @(posedge clk) begin
    if (!rstN) busyCyc <= 0;
    else       busyCyc <= busy ? busyCyc + 1 : 0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!busy && !done)); // R1
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCyc == LAT)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R3
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy); // R4
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R4
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done)); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> busy); // R5
endmodule

bind ring_mac_array ring_mac_array_chk #(.N(N), .IN_CH(IN_CH), .OUT_CH(OUT_CH)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done)
);

// File: tb/sim_ring_mac_array.sv
`timescale 1ns/1ps
module sim_ring_mac_array;
  localparam int IN_CH  = 8;
  localparam int OUT_CH = 8;
  localparam int NDUT   = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       ldWe = 1'b0, ldAe = 1'b0;
  logic [2:0] ldRow = '0, ldCol = '0, rdRow = '0;
  logic [7:0] ldData = '0;
  logic        busyV [NDUT];
  logic        doneV [NDUT];
  logic [31:0] rdV   [NDUT];

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  byte wRef [OUT_CH][IN_CH];
  byte aRef [IN_CH];

  always #5 clk = ~clk;

  ring_mac_array #(.N(4), .IN_CH(IN_CH), .OUT_CH(OUT_CH)) u0 (
    .clk(clk), .rstN(rstN), .ldWe(ldWe), .ldAe(ldAe), .ldRow(ldRow), .ldCol(ldCol),
    .ldData(ldData), .start(start), .busy(busyV[0]), .done(doneV[0]),
    .rdRow(rdRow), .rdData(rdV[0]));
  ring_mac_array #(.N(2), .IN_CH(IN_CH), .OUT_CH(OUT_CH)) u1 (
    .clk(clk), .rstN(rstN), .ldWe(ldWe), .ldAe(ldAe), .ldRow(ldRow), .ldCol(ldCol),
    .ldData(ldData), .start(start), .busy(busyV[1]), .done(doneV[1]),
    .rdRow(rdRow), .rdData(rdV[1]));
  ring_mac_array #(.N(1), .IN_CH(IN_CH), .OUT_CH(OUT_CH)) u2 (
    .clk(clk), .rstN(rstN), .ldWe(ldWe), .ldAe(ldAe), .ldRow(ldRow), .ldCol(ldCol),
    .ldData(ldData), .start(start), .busy(busyV[2]), .done(doneV[2]),
    .rdRow(rdRow), .rdData(rdV[2]));

  function automatic int ringSize(int d);
    return (d == 0) ? 4 : ((d == 1) ? 2 : 1);
  endfunction

  function automatic int expLatency(int d);
    return (IN_CH * OUT_CH) / ringSize(d) + ringSize(d);
  endfunction

  function automatic logic [31:0] refOut(int oc);
    int s = 0;
    for (int ic = 0; ic < IN_CH; ic++) s += int'(wRef[oc][ic]) * int'(aRef[ic]);
    return 32'(s);
  endfunction

  task automatic check(bit ok, string req, int d, longint actual, longint expected);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s N=%0d actual=%0d expected=%0d", req, ringSize(d), actual, expected);
    end
  endtask

  task automatic putW(int oc, int ic, byte v);
    @(negedge clk);
    ldWe = 1'b1; ldRow = 3'(oc); ldCol = 3'(ic); ldData = 8'(v);
    @(negedge clk);
    ldWe = 1'b0;
  endtask

  task automatic putA(int ic, byte v);
    @(negedge clk);
    ldAe = 1'b1; ldCol = 3'(ic); ldData = 8'(v);
    @(negedge clk);
    ldAe = 1'b0;
  endtask

  task automatic loadAll();
    for (int oc = 0; oc < OUT_CH; oc++)
      for (int ic = 0; ic < IN_CH; ic++) putW(oc, ic, wRef[oc][ic]);
    for (int ic = 0; ic < IN_CH; ic++) putA(ic, aRef[ic]);
  endtask

  task automatic compareAll(string req);
    for (int oc = 0; oc < OUT_CH; oc++) begin
      rdRow = 3'(oc);
      #1;
      for (int d = 0; d < NDUT; d++)
        check(rdV[d] == refOut(oc), req, d, longint'(signed'(rdV[d])),
              longint'(signed'(refOut(oc))));
    end
  endtask

  // Start a run; optionally poke start and the load port mid-run (R5, R6)
  task automatic runCheck(string req, bit inject);
    int got [NDUT];
    bit busyBad [NDUT];
    for (int d = 0; d < NDUT; d++) begin got[d] = 0; busyBad[d] = 0; end
    @(negedge clk);
    start = 1'b1;
    for (int cnt = 1; cnt <= 80; cnt++) begin
      @(posedge clk);
      @(negedge clk);
      if (cnt == 1) start = 1'b0;
      if (inject && cnt == 5) begin
        start = 1'b1; ldWe = 1'b1; ldAe = 1'b1;
        ldRow = 3'd0; ldCol = 3'd0; ldData = 8'h55;
      end
      if (inject && cnt == 6) begin
        start = 1'b0; ldWe = 1'b0; ldAe = 1'b0;
      end
      for (int d = 0; d < NDUT; d++) begin
        if (got[d] == 0 && !busyV[d]) busyBad[d] = 1;
        if (got[d] != 0 && cnt == got[d] + 1) begin
          check(!doneV[d], "R3 done width", d, longint'(doneV[d]), 0);
          check(!busyV[d], "R4 busy after done", d, longint'(busyV[d]), 0);
        end
        if (doneV[d] && got[d] == 0) got[d] = cnt;
      end
    end
    for (int d = 0; d < NDUT; d++) begin
      check(got[d] == expLatency(d), inject ? "R5 latency" : "R3 latency", d,
            got[d], expLatency(d));
      check(!busyBad[d], "R4 busy during run", d, busyBad[d], 0);
    end
    compareAll(req);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int d = 0; d < NDUT; d++) begin
      check(!busyV[d], "R1 busy", d, longint'(busyV[d]), 0);
      check(!doneV[d], "R1 done", d, longint'(doneV[d]), 0);
    end
    for (int oc = 0; oc < OUT_CH; oc++) begin
      rdRow = 3'(oc);
      #1;
      for (int d = 0; d < NDUT; d++) check(rdV[d] == 0, "R1 result", d, rdV[d], 0);
    end

    // R2: random data
    for (int oc = 0; oc < OUT_CH; oc++)
      for (int ic = 0; ic < IN_CH; ic++) wRef[oc][ic] = byte'($urandom);
    for (int ic = 0; ic < IN_CH; ic++) aRef[ic] = byte'($urandom);
    loadAll();
    runCheck("R2 random", 0);

    // R2 corner: most negative values everywhere; R5/R6 mid-run pokes
    for (int oc = 0; oc < OUT_CH; oc++)
      for (int ic = 0; ic < IN_CH; ic++) wRef[oc][ic] = -128;
    for (int ic = 0; ic < IN_CH; ic++) aRef[ic] = -128;
    loadAll();
    runCheck("R5 R6 busy pokes", 1);
    // R7: restart without reload
    runCheck("R7 restart", 0);

    // R2 corner: mixed extremes and zeros
    for (int oc = 0; oc < OUT_CH; oc++)
      for (int ic = 0; ic < IN_CH; ic++)
        wRef[oc][ic] = (oc % 3 == 0) ? 8'sd0 : ((ic % 2 == 0) ? 8'sd127 : -8'sd128);
    for (int ic = 0; ic < IN_CH; ic++) aRef[ic] = (ic < 4) ? -8'sd128 : 8'sd127;
    loadAll();
    runCheck("R2 extremes", 0);

    // R8: single writes after a rotated run
    wRef[5][2] = -8'sd77; putW(5, 2, wRef[5][2]);
    aRef[6] = 8'sd99;     putA(6, aRef[6]);
    aRef[1] = -8'sd3;     putA(1, aRef[1]);
    runCheck("R8 idle writes", 0);

    // R2/R7: more random rounds
    for (int k = 0; k < 4; k++) begin
      for (int oc = 0; oc < OUT_CH; oc++)
        for (int ic = 0; ic < IN_CH; ic++) wRef[oc][ic] = byte'($urandom);
      for (int ic = 0; ic < IN_CH; ic++) aRef[ic] = byte'($urandom);
      loadAll();
      runCheck("R2 random round", 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule